// File: doc/BRIEF.md
# Eight-Channel LED Brightness and Blink Controller

This block produces eight LED enable signals from a small set of configuration registers. Each channel has an 8-bit brightness value that sets the duty cycle of a fast pulse-width signal. A pair of shared registers drives a slower group signal. Depending on a control bit, that group signal is either a global dimming PWM or a blink with a programmable period and on-ratio. A 2-bit state per channel selects whether the channel is forced off, forced on, driven by its own PWM alone, or driven by its own PWM gated by the group signal.

The registers are written and read through a plain address/data port. Writes to the brightness, group and state registers first land in shadow storage. They become visible only on a commit event. The host interface reports two kinds of event: the end of a transfer (`busStop`) and the acknowledge of a single byte (`byteAck`). A control bit picks which of the two commits. A `sleep` input stops and clears the whole timebase, which makes all PWM-driven channels dark.

Top module: `led_pwm_ctrl`

## Requirements
- R1: After reset every read returns the reset value: address 0 (control) 00h, addresses 1 to 8 (channel brightness, channel n at address 1+n) 00h, address 9 (group duty) FFh, address 10 (blink period) 00h, addresses 11 and 12 (channel states) 00h, and `ledOut` is all zero. Unmapped addresses read 00h.
- R2: A channel whose state is 00 is held off, and a channel whose state is 01 is held on, regardless of any duty value, group setting or sleep.
- R3: In state 10 a channel is on exactly while the individual counter is below its brightness value. The counter is 8 bits and advances once every PWM_DIV clocks, so brightness 00h never lights the channel and FFh lights it for 255 of 256 steps.
- R4: In state 11 with control bit 0 clear (dimming), a channel is the AND of its individual PWM and a group PWM. The group PWM is on while an 8-bit group counter, advancing once every GRP_DIV individual steps, is below the group duty. The blink-period register has no effect.
- R5: In state 11 with control bit 0 set (blinking), the group signal has a period of (P+1)*256*BLINK_STEP clocks, where P is the blink-period register. It is on while the index of the current 1/256 step of that period is below the group duty.
- R6: Channel n takes its state from bits [2(n mod 4)+1 : 2(n mod 4)] of address 11 for channels 0 to 3, and of address 12 for channels 4 to 7.
- R7: With control bit 1 clear, writes to addresses 1 to 12 change neither reads nor outputs until a `busStop` pulse, and `byteAck` has no effect. A write to address 0 takes effect immediately.
- R8: With control bit 1 set, pending writes are committed by `byteAck`, and `busStop` has no effect.
- R9: While `sleep` is high, all timebase counters are cleared and held. Channels in states 10 and 11 are off. After `sleep` falls, the counters start again from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep | input | 1 | Stops and clears the timebase |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 4 | Read address |
| rdData | output | 8 | Committed value at rdAddr (combinational) |
| busStop | input | 1 | End-of-transfer commit event |
| byteAck | input | 1 | Per-byte acknowledge commit event |
| ledOut | output | 8 | Channel enables |

## Verification
On every cycle, the assertions check the channel-state rules: state 00 dark, state 01 lit, zero brightness dark, and PWM channels dark in sleep. They also check that committed configuration never moves without a commit event. The cycle-exact PWM, dimming and blink waveforms are shown only by the bench, which compares `ledOut` every clock against a timing model. The choice between commit events and the bit packing of the state fields are shown only by the bench's write, event and readback scenarios.

// File: rtl/ledc_pkg.sv
package ledc_pkg;
  localparam int CH_NUM = 8;
  localparam int DUTY_W = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_DUTY0  = 4'd1;
  localparam logic [ADDR_W-1:0] A_GDUTY  = 4'd9;
  localparam logic [ADDR_W-1:0] A_PERIOD = 4'd10;
  localparam logic [ADDR_W-1:0] A_STLO   = 4'd11;
  localparam logic [ADDR_W-1:0] A_STHI   = 4'd12;

  typedef enum logic [1:0] {
    ST_OFF  = 2'b00,
    ST_ON   = 2'b01,
    ST_IND  = 2'b10,
    ST_GRP  = 2'b11
  } chState_e;

  typedef struct packed {
    logic [CH_NUM-1:0][DUTY_W-1:0] duty;
    logic [CH_NUM-1:0][1:0]        state;
    logic [DUTY_W-1:0]             grpDuty;
    logic [DUTY_W-1:0]             period;
    logic                          blinkSel;
    logic                          ackSel;
  } ledc_cfg_t;

  typedef struct packed {
    logic hold;
    logic pwmStep;
    logic grpStep;
    logic blinkStep;
  } ledc_stb_t;
endpackage

// File: rtl/ledc_regs.sv
module ledc_regs
  import ledc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DUTY_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DUTY_W-1:0] rdData,
  input  logic              busStop,
  input  logic              byteAck,
  output ledc_cfg_t         cfg,
  output logic              commitNow
);
  localparam int ST_BYTES = (2 * CH_NUM) / DUTY_W;

  logic [CH_NUM-1:0][DUTY_W-1:0] dutySh;
  logic [2*CH_NUM-1:0]           stateSh;
  logic [2*CH_NUM-1:0]           stateCm;
  logic [DUTY_W-1:0]             gDutySh;
  logic [DUTY_W-1:0]             periodSh;
  logic [1:0]                    ctrlReg;

  assign commitNow = ctrlReg[1] ? byteAck : busStop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlReg  <= '0;
      dutySh   <= '0;
      stateSh  <= '0;
      gDutySh  <= '1;
      periodSh <= '0;
    end else if (wrEn) begin
      if (wrAddr == A_CTRL)   ctrlReg  <= wrData[1:0];
      if (wrAddr == A_GDUTY)  gDutySh  <= wrData;
      if (wrAddr == A_PERIOD) periodSh <= wrData;
      if (wrAddr == A_STLO)   stateSh[DUTY_W-1:0] <= wrData;
      if (wrAddr == A_STHI)   stateSh[2*DUTY_W-1:DUTY_W] <= wrData;
      for (int i = 0; i < CH_NUM; i++)
        if (wrAddr == A_DUTY0 + ADDR_W'(i)) dutySh[i] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.duty    <= '0;
      stateCm     <= '0;
      cfg.grpDuty <= '1;
      cfg.period  <= '0;
    end else if (commitNow) begin
      cfg.duty    <= dutySh;
      stateCm     <= stateSh;
      cfg.grpDuty <= gDutySh;
      cfg.period  <= periodSh;
    end
  end

  assign cfg.blinkSel = ctrlReg[0];
  assign cfg.ackSel   = ctrlReg[1];

  for (genvar c = 0; c < CH_NUM; c++) begin : g_state
    assign cfg.state[c] = stateCm[2*c+1:2*c];
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      A_CTRL:   rdData = {{(DUTY_W-2){1'b0}}, ctrlReg};
      A_GDUTY:  rdData = cfg.grpDuty;
      A_PERIOD: rdData = cfg.period;
      A_STLO:   rdData = stateCm[DUTY_W-1:0];
      A_STHI:   rdData = stateCm[ST_BYTES*DUTY_W-1:DUTY_W];
      default: begin
        for (int i = 0; i < CH_NUM; i++)
          if (rdAddr == A_DUTY0 + ADDR_W'(i)) rdData = cfg.duty[i];
      end
    endcase
  end
endmodule

// File: rtl/ledc_timer.sv
module ledc_timer
  import ledc_pkg::*;
#(
  parameter int PWM_DIV    = 4,
  parameter int GRP_DIV    = 64,
  parameter int BLINK_STEP = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic [DUTY_W-1:0] period,
  output ledc_stb_t         stb
);
  localparam int PRE_W = $clog2(PWM_DIV + 1);
  localparam int GPR_W = $clog2(GRP_DIV + 1);
  localparam int BLK_W = $clog2((1 << DUTY_W) * BLINK_STEP + 1);

  logic [PRE_W-1:0] preCnt;
  logic [GPR_W-1:0] grpPre;
  logic [BLK_W-1:0] blkSub;
  logic [BLK_W-1:0] blkLimit;
  logic             hold;

  assign hold     = sleep || !rst_n;
  assign blkLimit = BLK_W'((32'(period) + 32'd1) * BLINK_STEP);

  assign stb.hold      = hold;
  assign stb.pwmStep   = !hold && (preCnt == PRE_W'(PWM_DIV - 1));
  assign stb.grpStep   = stb.pwmStep && (grpPre == GPR_W'(GRP_DIV - 1));
  assign stb.blinkStep = !hold && (blkSub >= blkLimit - BLK_W'(1));

  always_ff @(posedge clk) begin
    if (hold) begin
      preCnt <= '0;
      grpPre <= '0;
      blkSub <= '0;
    end else begin
      preCnt <= stb.pwmStep ? '0 : preCnt + PRE_W'(1);
      if (stb.pwmStep)
        grpPre <= stb.grpStep ? '0 : grpPre + GPR_W'(1);
      blkSub <= stb.blinkStep ? '0 : blkSub + BLK_W'(1);
    end
  end
endmodule

// File: rtl/ledc_datapath.sv
module ledc_datapath
  import ledc_pkg::*;
(
  input  logic              clk,
  input  ledc_stb_t         stb,
  input  ledc_cfg_t         cfg,
  output logic [CH_NUM-1:0] ledOut
);
  logic [DUTY_W-1:0] indCnt;
  logic [DUTY_W-1:0] grpCnt;
  logic [DUTY_W-1:0] blkIdx;
  logic              grpOn;

  always_ff @(posedge clk) begin
    if (stb.hold) begin
      indCnt <= '0;
      grpCnt <= '0;
      blkIdx <= '0;
    end else begin
      if (stb.pwmStep)   indCnt <= indCnt + DUTY_W'(1);
      if (stb.grpStep)   grpCnt <= grpCnt + DUTY_W'(1);
      if (stb.blinkStep) blkIdx <= blkIdx + DUTY_W'(1);
    end
  end

  assign grpOn = cfg.blinkSel ? (blkIdx < cfg.grpDuty) : (grpCnt < cfg.grpDuty);

  for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
    logic indOn;
    assign indOn = indCnt < cfg.duty[c];
    always_comb begin
      case (chState_e'(cfg.state[c]))
        ST_OFF:  ledOut[c] = 1'b0;
        ST_ON:   ledOut[c] = 1'b1;
        ST_IND:  ledOut[c] = !stb.hold && indOn;
        default: ledOut[c] = !stb.hold && indOn && grpOn;
      endcase
    end
  end
endmodule

// File: rtl/led_pwm_ctrl.sv
module led_pwm_ctrl
  import ledc_pkg::*;
#(
  parameter int PWM_DIV    = 4,
  parameter int GRP_DIV    = 64,
  parameter int BLINK_STEP = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sleep,
  input  logic        wrEn,
  input  logic [3:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic [3:0]  rdAddr,
  output logic [7:0]  rdData,
  input  logic        busStop,
  input  logic        byteAck,
  output logic [7:0]  ledOut
);
  ledc_cfg_t cfg;
  ledc_stb_t stb;
  logic      commitNow;

  ledc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .busStop(busStop), .byteAck(byteAck),
    .cfg(cfg), .commitNow(commitNow)
  );

  ledc_timer #(.PWM_DIV(PWM_DIV), .GRP_DIV(GRP_DIV), .BLINK_STEP(BLINK_STEP)) u_timer (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .period(cfg.period), .stb(stb)
  );

  ledc_datapath u_dp (
    .clk(clk), .stb(stb), .cfg(cfg), .ledOut(ledOut)
  );
endmodule

// File: rtl/ledc_checker.sv
module ledc_checker
  import ledc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic [CH_NUM-1:0] ledOut,
  input ledc_cfg_t         cfg,
  input logic              commitNow
);
  for (genvar c = 0; c < CH_NUM; c++) begin : g_chk
    p_off_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.state[c] == 2'b00) |-> !ledOut[c]);
    p_on_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.state[c] == 2'b01) |-> ledOut[c]);
    p_zero_duty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.state[c][1] && cfg.duty[c] == '0) |-> !ledOut[c]);
    p_sleep_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep && cfg.state[c][1]) |-> !ledOut[c]);
  end

  p_commit_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !commitNow |=> $stable({cfg.duty, cfg.state, cfg.grpDuty, cfg.period}));
endmodule

bind led_pwm_ctrl ledc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .ledOut(ledOut),
  .cfg(cfg), .commitNow(commitNow)
);

// File: tb/led_pwm_ctrl_test.sv
module led_pwm_ctrl_test;
  localparam int PD = 1;
  localparam int GD = 2;
  localparam int BS = 1;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       sleep = 1;
  logic       wrEn = 0;
  logic [3:0] wrAddr = 0;
  logic [7:0] wrData = 0;
  logic [3:0] rdAddr = 0;
  logic [7:0] rdData;
  logic       busStop = 0;
  logic       byteAck = 0;
  logic [7:0] ledOut;

  int nChk = 0;
  int nFail = 0;
  int mCnt = 0;
  bit done = 0;
  logic [7:0] shReg [13];
  logic [7:0] cmReg [13];

  led_pwm_ctrl #(.PWM_DIV(PD), .GRP_DIV(GD), .BLINK_STEP(BS)) uut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .busStop(busStop),
    .byteAck(byteAck), .ledOut(ledOut)
  );

  always #5 clk = ~clk;

  always @(posedge clk) mCnt <= sleep ? 0 : mCnt + 1;

  task automatic check(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic bit expLed(int ch, int m);
    int st, duty, g, p, lim;
    bit ind, grp;
    st = (cmReg[11 + ch/4] >> (2 * (ch % 4))) & 3;
    duty = cmReg[1 + ch];
    g = cmReg[9];
    p = cmReg[10];
    lim = (p + 1) * BS;
    if (st == 0) return 0;
    if (st == 1) return 1;
    if (sleep) return 0;
    ind = ((m / PD) % 256) < duty;
    if (st == 2) return ind;
    if (cmReg[0][0]) grp = ((m / lim) % 256) < g;
    else grp = ((m / (PD * GD)) % 256) < g;
    return ind && grp;
  endfunction

  function automatic logic [7:0] expVec(int m);
    logic [7:0] v;
    for (int c = 0; c < 8; c++) v[c] = expLed(c, m);
    return v;
  endfunction

  task automatic writeReg(int a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = 4'(a); wrData = d;
    @(negedge clk);
    wrEn = 0;
    shReg[a] = d;
    if (a == 0) cmReg[0] = d & 8'h03;
  endtask

  task automatic pulseEvt(bit isAck);
    @(negedge clk);
    if (isAck) byteAck = 1; else busStop = 1;
    @(negedge clk);
    byteAck = 0; busStop = 0;
    if (isAck == cmReg[0][1])
      for (int i = 1; i < 13; i++) cmReg[i] = shReg[i];
  endtask

  task automatic readChk(int a, string req);
    @(negedge clk);
    rdAddr = 4'(a);
    #1;
    check(rdData === cmReg[a], req, rdData, cmReg[a]);
  endtask

  task automatic runWindow(int n, string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(ledOut === expVec(mCnt), req, ledOut, expVec(mCnt));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      nChk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 13; i++) begin
      shReg[i] = 8'h00;
      cmReg[i] = 8'h00;
    end
    shReg[9] = 8'hFF;
    cmReg[9] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset values of every register and the outputs
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      rdAddr = 4'(a);
      #1;
      check(rdData === ((a == 9) ? 8'hFF : 8'h00), "R1 reset read", rdData,
            (a == 9) ? 8'hFF : 8'h00);
    end
    check(ledOut === 8'h00, "R1 reset outputs", ledOut, 0);

    // R6/R2/R9: program states while asleep: ch0 on, ch1 off, others PWM
    writeReg(1, 8'h00);
    writeReg(2, 8'h80);
    writeReg(3, 8'hFF);
    writeReg(4, 8'h00);
    for (int c = 4; c < 8; c++) writeReg(1 + c, 8'($urandom_range(255, 1)));
    writeReg(9, 8'h90);
    writeReg(10, 8'h05);           // period ignored in dimming mode (R4)
    writeReg(11, 8'b11_10_00_01);  // ch3=11 ch2=10 ch1=00 ch0=01
    writeReg(12, 8'b10_11_10_11);
    check(ledOut === 8'h00, "R7 outputs unchanged before commit", ledOut, 0);
    pulseEvt(1);                   // ack ignored while stop mode selected
    readChk(11, "R7 ack ignored in stop mode");
    pulseEvt(0);
    readChk(11, "R6 state low byte committed");
    readChk(12, "R6 state high byte committed");
    readChk(2, "R7 brightness committed on stop");
    runWindow(4, "R9 asleep: PWM channels dark, on channel lit");

    // R3/R4: wake and compare every cycle across individual and group periods
    @(negedge clk);
    sleep = 0;
    runWindow(1200, "R3/R4 PWM with group dimming");

    // R7: pending brightness stays invisible until stop
    writeReg(2, 8'h20);
    writeReg(11, 8'b11_10_01_01);
    readChk(2, "R7 read returns committed value while pending");
    runWindow(20, "R7 output unaffected by pending write");
    pulseEvt(0);
    readChk(2, "R7 new value after stop");
    runWindow(300, "R3 after commit");

    // R8: acknowledge-driven commit
    writeReg(0, 8'h02);
    readChk(0, "R7 control write immediate");
    writeReg(5, 8'h11);
    pulseEvt(0);
    readChk(5, "R8 stop ignored in ack mode");
    pulseEvt(1);
    readChk(5, "R8 ack commits");

    // R9: sleep mid-run, then restart from zero
    @(negedge clk);
    sleep = 1;
    runWindow(10, "R9 sleep mid-run");

    // R5: blink mode, period 3 units
    writeReg(0, 8'h03);
    writeReg(10, 8'h02);
    writeReg(9, 8'h60);
    for (int c = 0; c < 8; c++) writeReg(1 + c, (c == 3) ? 8'h00 : 8'hFF);
    writeReg(11, 8'b11_11_11_11);
    writeReg(12, 8'b11_11_11_10);
    pulseEvt(1);
    readChk(10, "R5 period committed");
    @(negedge clk);
    sleep = 0;
    runWindow(1600, "R5 blink pattern");

    // R3 random brightness with group duty FFh in blink mode
    for (int c = 0; c < 8; c++) writeReg(1 + c, 8'($urandom_range(255, 0)));
    writeReg(9, 8'hFF);
    pulseEvt(1);
    runWindow(800, "R3/R5 random brightness");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule